// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Protocol Monitor

This block watches the control and address pins of a DDR SDRAM interface. On every rising clock edge it samples chip select, the three strobes (row strobe, column strobe, write enable), clock enable, the bank bits and the address bits. From these it produces a one-hot command code. The monitor keeps its own copy of the device state: which banks are open, which row each open bank holds, whether a read or write burst is running and whether that burst will auto-precharge. It also keeps the last opcodes loaded into the mode register and the extended mode register.

Commands that break the protocol produce a one-cycle error pulse on one of four flags. A command that raises an error has no effect on the tracked state. This lets the monitor sit beside a memory controller in simulation, or in silicon as a bus checker, and report misuse of the protocol as it happens. Data-path timing, strobe capture, write masking and refresh interval policing are not part of this block.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: `cmd_onehot` is combinational from the pins and always has exactly one bit set. The bit positions are: 0 deselect (chip select high), 1 no-op, 2 activate, 3 read, 4 write, 5 burst stop, 6 precharge, 7 auto refresh, 8 self refresh, 9 mode load, 10 illegal. With CKE high and chip select low, the strobes {ras_n,cas_n,we_n} decode as follows: 111 no-op, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 001 refresh, 000 mode load. Deselect and no-op change no tracked state.
- R2: With CKE low, the refresh encoding decodes as self refresh (bit 8). Every other pin combination, deselect included, decodes as illegal (bit 10). An illegal command raises `err_illegal` in the next cycle and changes no state.
- R3: Activate to a closed bank opens the bank selected by `ba` and latches all of `addr` as its row. The row appears on `open_row[b*13 +: 13]`.
- R4: Activate to a bank that is already open raises `err_protocol`. The bank's stored row is left unchanged.
- R5: Precharge with addr[10] low closes only the bank named by `ba`. Precharge with addr[10] high closes every bank and ignores `ba`.
- R6: A read or write is rejected, with `err_protocol` raised and no burst started, in two cases: its bank is closed, or an auto-precharge burst is still running.
- R7: An accepted read or write sets `burst_active` from the next cycle for BL/2 cycles. The burst length BL comes from mode_reg[2:0]: 001 gives 2, 010 gives 4, 011 gives 8, and any other code gives 2. `burst_is_write` shows the burst type, and `burst_autopre` holds addr[10] of the command.
- R8: A burst started with addr[10] high closes its bank at the clock edge where the burst ends.
- R9: Burst stop ends a running read burst that has no auto-precharge at that edge. In every other situation (a write burst, an auto-precharge read burst, or no burst) it raises `err_burst_stop` and the burst continues.
- R10: Auto or self refresh while any bank is open raises `err_protocol`.
- R11: Mode load with ba=00 writes `addr` into `mode_reg`, and with ba=01 into `ext_mode_reg`. With ba=10 or 11 it raises `err_reserved` and leaves both registers unchanged.
- R12: After reset all banks are closed, both mode registers are zero, no burst runs and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge samples the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row, column or opcode bits |
| cmd_onehot | output | 11 | Decoded command, one-hot |
| bank_open | output | 4 | One bit per bank, high when open |
| open_row | output | 52 | Stored row per bank, 13 bits each |
| burst_active | output | 1 | A burst is running |
| burst_is_write | output | 1 | Running burst is a write |
| burst_autopre | output | 1 | Running burst will auto-precharge |
| mode_reg | output | 13 | Last mode register opcode |
| ext_mode_reg | output | 13 | Last extended mode register opcode |
| err_illegal | output | 1 | Pulse: illegal pin combination |
| err_protocol | output | 1 | Pulse: bank state or refresh rule broken |
| err_burst_stop | output | 1 | Pulse: burst stop used where not allowed |
| err_reserved | output | 1 | Pulse: mode load to a reserved bank code |

## Verification
The bench targets these corner cases:
- It sends burst stop during a write, during an auto-precharge read, and with no burst running. A design that accepted any of these would drop `burst_active` early and stay silent on `err_burst_stop`.
- It issues a precharge with addr[10] high while `ba` points at a bank that is already closed. Any design that decodes the bank bits in this case would leave other banks open.
- It counts burst cycles at lengths 2, 4 and 8, and it checks that an auto-precharge bank stays open during the last beat and closes only after it. An off-by-one counter shows up as a wrong count or an early close.
- It sends a read inside an auto-precharge burst, a repeated activate to the same bank, and mode loads to reserved bank codes. A design that accepted these would start a burst, overwrite the stored row or corrupt the mode registers.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;
  localparam int CMD_N  = 11;
  localparam int C_DESEL = 0;
  localparam int C_NOP   = 1;
  localparam int C_ACT   = 2;
  localparam int C_RD    = 3;
  localparam int C_WR    = 4;
  localparam int C_BST   = 5;
  localparam int C_PRE   = 6;
  localparam int C_AREF  = 7;
  localparam int C_SREF  = 8;
  localparam int C_LMR   = 9;
  localparam int C_ILL   = 10;

  localparam int BCNT_W = 2;

  // beats minus one for a burst-length code (BL/2 - 1)
  function automatic logic [BCNT_W-1:0] beats_m1(input logic [2:0] bl_code);
    case (bl_code)
      3'd2:    beats_m1 = 2'd1;
      3'd3:    beats_m1 = 2'd3;
      default: beats_m1 = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
(
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             cke,
  output logic [CMD_N-1:0] cmd
);
  logic [2:0] strobes;
  assign strobes = {ras_n, cas_n, we_n};

  always_comb begin
    cmd = '0;
    if (!cke) begin
      if (!cs_n && strobes == 3'b001) cmd[C_SREF] = 1'b1;
      else                            cmd[C_ILL]  = 1'b1;
    end else if (cs_n) begin
      cmd[C_DESEL] = 1'b1;
    end else begin
      case (strobes)
        3'b111:  cmd[C_NOP]  = 1'b1;
        3'b011:  cmd[C_ACT]  = 1'b1;
        3'b101:  cmd[C_RD]   = 1'b1;
        3'b100:  cmd[C_WR]   = 1'b1;
        3'b110:  cmd[C_BST]  = 1'b1;
        3'b010:  cmd[C_PRE]  = 1'b1;
        3'b001:  cmd[C_AREF] = 1'b1;
        default: cmd[C_LMR]  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
  parameter int BA_W  = 2,
  parameter int ROW_W = 13,
  localparam int NBANK = 1 << BA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   act_en,
  input  logic [BA_W-1:0]        act_bank,
  input  logic [ROW_W-1:0]       act_row,
  input  logic                   close_one,
  input  logic [BA_W-1:0]        close_bank,
  input  logic                   close_all,
  input  logic                   ap_close,
  input  logic [BA_W-1:0]        ap_bank,
  output logic [NBANK-1:0]       bank_open,
  output logic [NBANK*ROW_W-1:0] open_row
);
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic             open_q, open_d;
    logic [ROW_W-1:0] row_q;
    logic             row_en, close_hit;

    always_comb begin
      row_en    = act_en && (act_bank == BA_W'(g));
      close_hit = close_all
               || (close_one && (close_bank == BA_W'(g)))
               || (ap_close  && (ap_bank    == BA_W'(g)));
      open_d = open_q;
      if (close_hit)   open_d = 1'b0;
      else if (row_en) open_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else begin
        open_q <= open_d;
        if (row_en) row_q <= act_row;
      end
    end

    assign bank_open[g]                  = open_q;
    assign open_row[g*ROW_W +: ROW_W]    = row_q;

    assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act_en && act_bank == BA_W'(g)) |=> (bank_open[g] && open_row[g*ROW_W +: ROW_W] == $past(act_row)));

    assert_close_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      close_all |=> !bank_open[g]);
  end
endmodule

// File: rtl/ddr_burst_tracker.sv
module ddr_burst_tracker
  import ddr_mon_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_wr,
  input  logic            start_ap,
  input  logic [BA_W-1:0] start_bank,
  input  logic [2:0]      bl_code,
  input  logic            bst_ok,
  output logic            active,
  output logic            is_wr,
  output logic            autopre,
  output logic [BA_W-1:0] bank,
  output logic            ap_close
);
  logic              act_q, act_d, wr_q, wr_d, ap_q, ap_d;
  logic [BA_W-1:0]   bank_q, bank_d;
  logic [BCNT_W-1:0] cnt_q, cnt_d;
  logic              last_beat;

  assign last_beat = act_q && (cnt_q == '0);

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    ap_d   = ap_q;
    bank_d = bank_q;
    cnt_d  = cnt_q;
    if (start) begin
      act_d  = 1'b1;
      wr_d   = start_wr;
      ap_d   = start_ap;
      bank_d = start_bank;
      cnt_d  = beats_m1(bl_code);
    end else if (act_q) begin
      if (bst_ok || last_beat) act_d = 1'b0;
      else                     cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      ap_q   <= ap_d;
      bank_q <= bank_d;
      cnt_q  <= cnt_d;
    end
  end

  assign active   = act_q;
  assign is_wr    = wr_q;
  assign autopre  = ap_q;
  assign bank     = bank_q;
  assign ap_close = last_beat && ap_q && !start;

  assert_start_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && is_wr == $past(start_wr) && autopre == $past(start_ap)));

  assert_stop_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bst_ok |=> !active);
endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  localparam int NBANK = 1 << BA_W,
  localparam int ROW_W = ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic                   cke,
  input  logic [BA_W-1:0]        ba,
  input  logic [ADDR_W-1:0]      addr,
  output logic [CMD_N-1:0]       cmd_onehot,
  output logic [NBANK-1:0]       bank_open,
  output logic [NBANK*ROW_W-1:0] open_row,
  output logic                   burst_active,
  output logic                   burst_is_write,
  output logic                   burst_autopre,
  output logic [ADDR_W-1:0]      mode_reg,
  output logic [ADDR_W-1:0]      ext_mode_reg,
  output logic                   err_illegal,
  output logic                   err_protocol,
  output logic                   err_burst_stop,
  output logic                   err_reserved
);
  logic [CMD_N-1:0] cmd;
  logic sel_open, is_rw, is_ref, act_ok, rw_ok, ap_busy;
  logic pre_one, pre_all, bst_ok, mr_wr, emr_wr, lmr_bad;
  logic ill_d, prot_d, bst_err_d;
  logic ap_close;
  logic [BA_W-1:0] burst_bank;
  logic [ADDR_W-1:0] mode_q, ext_q;
  logic ill_q, prot_q, bsterr_q, res_q;

  ddr_cmd_decode u_decode (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke), .cmd(cmd)
  );

  always_comb begin
    sel_open  = bank_open[ba];
    is_rw     = cmd[C_RD] | cmd[C_WR];
    is_ref    = cmd[C_AREF] | cmd[C_SREF];
    ap_busy   = burst_active && burst_autopre;
    act_ok    = cmd[C_ACT] && !sel_open;
    rw_ok     = is_rw && sel_open && !ap_busy;
    pre_one   = cmd[C_PRE] && !addr[AP_BIT];
    pre_all   = cmd[C_PRE] &&  addr[AP_BIT];
    bst_ok    = cmd[C_BST] && burst_active && !burst_is_write && !burst_autopre;
    mr_wr     = cmd[C_LMR] && (ba == BA_W'(0));
    emr_wr    = cmd[C_LMR] && (ba == BA_W'(1));
    lmr_bad   = cmd[C_LMR] && !mr_wr && !emr_wr;
    ill_d     = cmd[C_ILL];
    prot_d    = (cmd[C_ACT] && sel_open) || (is_rw && !rw_ok) || (is_ref && (|bank_open));
    bst_err_d = cmd[C_BST] && !bst_ok;
  end

  ddr_bank_tracker #(.BA_W(BA_W), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .act_en(act_ok), .act_bank(ba), .act_row(addr),
    .close_one(pre_one), .close_bank(ba), .close_all(pre_all),
    .ap_close(ap_close), .ap_bank(burst_bank),
    .bank_open(bank_open), .open_row(open_row)
  );

  ddr_burst_tracker #(.BA_W(BA_W)) u_burst (
    .clk(clk), .rst_n(rst_n),
    .start(rw_ok), .start_wr(cmd[C_WR]), .start_ap(addr[AP_BIT]), .start_bank(ba),
    .bl_code(mode_q[2:0]), .bst_ok(bst_ok),
    .active(burst_active), .is_wr(burst_is_write), .autopre(burst_autopre),
    .bank(burst_bank), .ap_close(ap_close)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      ext_q    <= '0;
      ill_q    <= 1'b0;
      prot_q   <= 1'b0;
      bsterr_q <= 1'b0;
      res_q    <= 1'b0;
    end else begin
      if (mr_wr)  mode_q <= addr;
      if (emr_wr) ext_q  <= addr;
      ill_q    <= ill_d;
      prot_q   <= prot_d;
      bsterr_q <= bst_err_d;
      res_q    <= lmr_bad;
    end
  end

  assign cmd_onehot     = cmd;
  assign mode_reg       = mode_q;
  assign ext_mode_reg   = ext_q;
  assign err_illegal    = ill_q;
  assign err_protocol   = prot_q;
  assign err_burst_stop = bsterr_q;
  assign err_reserved   = res_q;

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmd_onehot) == 1);

  assert_idle_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_onehot[C_NOP] || cmd_onehot[C_DESEL]) && !burst_active) |=> $stable(bank_open));

  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lmr_bad |=> (err_reserved && $stable(mode_reg) && $stable(ext_mode_reg)));

  assert_refresh_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && (|bank_open)) |=> err_protocol);

  assert_illegal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_onehot[C_ILL] |=> (err_illegal && $stable(bank_open)));
endmodule

// File: tb/ddr_cmd_monitor_bench.sv
module ddr_cmd_monitor_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, ras_n, cas_n, we_n, cke;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [10:0] cmd_onehot;
  logic [3:0]  bank_open;
  logic [51:0] open_row;
  logic burst_active, burst_is_write, burst_autopre;
  logic [12:0] mode_reg, ext_mode_reg;
  logic err_illegal, err_protocol, err_burst_stop, err_reserved;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_cmd_monitor u_ddr_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .ba(ba), .addr(addr), .cmd_onehot(cmd_onehot), .bank_open(bank_open),
    .open_row(open_row), .burst_active(burst_active), .burst_is_write(burst_is_write),
    .burst_autopre(burst_autopre), .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg),
    .err_illegal(err_illegal), .err_protocol(err_protocol),
    .err_burst_stop(err_burst_stop), .err_reserved(err_reserved)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive pins at a falling edge, return at the next falling edge
  task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                       input logic k, input logic [1:0] b, input logic [12:0] a);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; ba = b; addr = a;
    @(negedge clk);
  endtask

  task automatic nop();                              drive(0,1,1,1,1,2'd0,13'd0); endtask
  task automatic act(input logic [1:0] b, input logic [12:0] row); drive(0,0,1,1,1,b,row); endtask
  task automatic rd(input logic [1:0] b, input logic ap); drive(0,1,0,1,1,b,{2'b0,ap,10'h004}); endtask
  task automatic wr(input logic [1:0] b, input logic ap); drive(0,1,0,0,1,b,{2'b0,ap,10'h008}); endtask
  task automatic bst();                              drive(0,1,1,0,1,2'd0,13'd0); endtask
  task automatic pre(input logic [1:0] b, input logic all); drive(0,0,1,0,1,b,{2'b0,all,10'h0}); endtask
  task automatic refr(input logic k);                drive(0,0,0,1,k,2'd0,13'd0); endtask
  task automatic lmr(input logic [1:0] b, input logic [12:0] op); drive(0,0,0,0,1,b,op); endtask

  task automatic probe(input logic c, input logic r, input logic ca, input logic w,
                       input logic k, input int idx, input string req);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; ba = 2'd0; addr = 13'd0;
    #1;
    chk(req, 32'(cmd_onehot), 32'(1) << idx);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 banks closed", 32'(bank_open), 0);
    chk("R12 mode reg zero", 32'(mode_reg), 0);
    chk("R12 ext mode reg zero", 32'(ext_mode_reg), 0);
    chk("R12 no burst", 32'(burst_active), 0);
    chk("R12 no errors", 32'({err_illegal, err_protocol, err_burst_stop, err_reserved}), 0);
  endtask

  task automatic t_decode();
    probe(1,0,0,0,1, 0,  "R1 deselect");
    probe(0,1,1,1,1, 1,  "R1 nop");
    probe(0,0,0,0,1, 9,  "R1 mode load");
    probe(0,0,0,1,1, 7,  "R1 auto refresh");
    probe(0,0,0,1,0, 8,  "R2 self refresh");
    probe(0,1,1,1,0, 10, "R2 illegal cke low");
    probe(0,0,1,1,1, 2,  "R1 activate");
    probe(0,1,0,1,1, 3,  "R1 read");
    probe(0,1,1,0,1, 5,  "R1 burst stop");
    probe(0,1,0,0,1, 4,  "R1 write");
    cs_n = 0; ras_n = 0; cas_n = 1; we_n = 0; cke = 1; ba = 2'd0; addr = 13'h400;
    #1;
    chk("R1 precharge", 32'(cmd_onehot), 32'(1) << 6);
    @(negedge clk);
    chk("R5 all closed after decode sweep", 32'(bank_open), 0);
  endtask

  task automatic t_mode_regs();
    lmr(2'd0, 13'h0032);
    chk("R11 mode reg write", 32'(mode_reg), 32'h32);
    lmr(2'd1, 13'h1155);
    chk("R11 ext mode reg write", 32'(ext_mode_reg), 32'h1155);
    chk("R11 mode reg kept", 32'(mode_reg), 32'h32);
    lmr(2'd2, 13'h0fff);
    chk("R11 reserved flag ba=10", 32'(err_reserved), 1);
    chk("R11 mode reg unchanged", 32'(mode_reg), 32'h32);
    lmr(2'd3, 13'h0abc);
    chk("R11 reserved flag ba=11", 32'(err_reserved), 1);
    chk("R11 ext unchanged", 32'(ext_mode_reg), 32'h1155);
    nop();
    chk("R11 reserved flag clears", 32'(err_reserved), 0);
  endtask

  task automatic t_idle();
    act(2'd2, 13'h0101);
    drive(1,0,0,0,1,2'd2,13'h1fff);
    chk("R1 deselect keeps bank", 32'(bank_open), 32'b0100);
    nop();
    chk("R1 nop keeps row", 32'(open_row[2*13 +: 13]), 32'h0101);
    pre(2'd0, 1'b1);
  endtask

  task automatic t_activate();
    act(2'd1, 13'h1234);
    chk("R3 bank1 open", 32'(bank_open), 32'b0010);
    chk("R3 bank1 row", 32'(open_row[13 +: 13]), 32'h1234);
    act(2'd1, 13'h0777);
    chk("R4 reopen error", 32'(err_protocol), 1);
    chk("R4 row unchanged", 32'(open_row[13 +: 13]), 32'h1234);
    act(2'd2, 13'h0abc);
    chk("R3 bank2 row", 32'(open_row[26 +: 13]), 32'h0abc);
    chk("R4 error clears", 32'(err_protocol), 0);
  endtask

  task automatic t_precharge();
    pre(2'd1, 1'b0);
    chk("R5 single precharge", 32'(bank_open), 32'b0100);
    act(2'd3, 13'h0042);
    pre(2'd0, 1'b1);
    chk("R5 precharge all ignores ba", 32'(bank_open), 0);
  endtask

  task automatic t_closed_access();
    rd(2'd0, 1'b0);
    chk("R6 read closed error", 32'(err_protocol), 1);
    chk("R6 no burst", 32'(burst_active), 0);
    wr(2'd3, 1'b0);
    chk("R6 write closed error", 32'(err_protocol), 1);
  endtask

  task automatic t_burst_len(input logic [2:0] code, input int cycles, input string req);
    lmr(2'd0, {10'd0, code});
    act(2'd1, 13'h0011);
    rd(2'd1, 1'b0);
    for (int i = 0; i < cycles; i++) begin
      chk(req, 32'(burst_active), 1);
      nop();
    end
    chk(req, 32'(burst_active), 0);
    pre(2'd1, 1'b0);
  endtask

  task automatic t_write_burst();
    lmr(2'd0, 13'h0002);
    act(2'd0, 13'h0100);
    wr(2'd0, 1'b0);
    chk("R7 write type", 32'({burst_active, burst_is_write, burst_autopre}), 32'b110);
    bst();
    chk("R9 stop on write flagged", 32'(err_burst_stop), 1);
    chk("R9 write burst continues", 32'(burst_active), 1);
    nop();
    chk("R7 write burst ends", 32'(burst_active), 0);
    rd(2'd0, 1'b0);
    bst();
    chk("R9 legal stop no error", 32'(err_burst_stop), 0);
    chk("R9 legal stop ends burst", 32'(burst_active), 0);
    bst();
    chk("R9 stop without burst flagged", 32'(err_burst_stop), 1);
  endtask

  task automatic t_autopre();
    rd(2'd0, 1'b1);
    chk("R7 autopre read", 32'({burst_active, burst_is_write, burst_autopre}), 32'b101);
    nop();
    chk("R8 bank open in last beat", 32'(bank_open[0]), 1);
    nop();
    chk("R8 bank closed after burst", 32'(bank_open[0]), 0);
    act(2'd0, 13'h0200);
    rd(2'd0, 1'b1);
    bst();
    chk("R9 stop on autopre read flagged", 32'(err_burst_stop), 1);
    nop();
    chk("R8 closes despite stop", 32'({burst_active, bank_open[0]}), 0);
    act(2'd0, 13'h0300);
    wr(2'd0, 1'b1);
    rd(2'd0, 1'b0);
    chk("R6 access during autopre burst", 32'(err_protocol), 1);
    nop();
    chk("R6 rejected access leaves no burst", 32'({burst_active, bank_open[0]}), 0);
  endtask

  task automatic t_refresh();
    act(2'd2, 13'h0055);
    refr(1'b1);
    chk("R10 auto refresh with open bank", 32'(err_protocol), 1);
    drive(0,1,1,1,0,2'd0,13'd0);
    chk("R2 illegal flag", 32'(err_illegal), 1);
    chk("R2 illegal keeps state", 32'(bank_open), 32'b0100);
    pre(2'd0, 1'b1);
    refr(1'b1);
    chk("R10 refresh all closed ok", 32'(err_protocol), 0);
    refr(1'b0);
    chk("R2 self refresh not illegal", 32'(err_illegal), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; cke = 1; ba = 0; addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_mode_regs();
    t_idle();
    t_activate();
    t_precharge();
    t_closed_access();
    t_burst_len(3'd1, 1, "R7 length 2");
    t_burst_len(3'd2, 2, "R7 length 4");
    t_burst_len(3'd3, 4, "R7 length 8");
    t_write_burst();
    t_autopre();
    t_refresh();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule